// File: doc/BRIEF.md
# Slot-Scheduled Network Interface with End-to-End Credits

This block is the send and receive half of one node's attachment to a time-multiplexed network. Several logical connections share the link. Time is cut into slots of a fixed number of word cycles. A programmable slot table names the connection that owns each slot, and the table repeats once its active entries are used up. Each connection has its own transmit queue, its own receive queue, a counter of free space in the far end's receive queue, and a count of credits it still owes the far end.

In a slot it owns, a connection may start a packet. A packet begins with a header word, except when the same connection owned the previous slot and already had a packet open there. Payload words go out only while the connection has data queued and its space counter is above zero. Words that the local consumer drains from a receive queue turn into owed credits. These credits go back inside the header's 5-bit credit field. Credits that arrive in received headers refill the space counter of the connection named in the header.

Data streams use valid/ready. A word moves when valid and ready are both high on a rising edge. The transmit queue drops ready when it is full. The receive side holds valid while its queue has data. The link itself has no back-pressure. An incoming payload word must always find room, and the credit scheme guarantees this. Link output is registered and appears one cycle after the word slot it belongs to.

Top module: `tdma_ni`

## Requirements
- R1: After reset the link output is idle, every transmit queue is ready, no receive queue is valid, the slot table holds one active entry owned by connection 0, and each space counter starts at RMT_DEPTH. A connection can therefore put exactly RMT_DEPTH payload words on the link before any credit comes back.
- R2: While `run` is high, each slot lasts WPS cycles. Slots follow table entries 0, 1, ... up to the active length minus 1 and then wrap to entry 0. The length can be set from 1 to SLOTS_MAX.
- R3: Table entries and the length change only when written while `run` is low. A write while `run` is high has no effect.
- R4: A header is only ever the first word of a slot. Header layout: bits [4:0] hold the returned credit count and bits [5 +: CW] hold the connection number. The header is left out, and every word of the slot is payload, when three conditions hold: the previous slot had the same owner, that slot carried a packet, and the owner owes no credits.
- R5: A payload word for a connection is sent only when its transmit queue is not empty and its space counter is nonzero. Each payload word sent lowers the counter by one.
- R6: Queues are per connection. A connection that is out of space or has no data never holds back traffic of another connection.
- R7: Each word drained from a receive queue adds one owed credit to that connection. Owed credits are returned only in a header sent in a slot the connection owns, at most 31 per header. Any excess waits for a later header.
- R8: A received header adds its credit field to the space counter of the connection it names. The payload words that follow go, in order, to that connection's receive queue, and each connection's data comes out in the order it went in.
- R9: If the slot owner has no data or no space but does owe credits, a header is still sent to carry them. If it has no data or no space and owes nothing, the slot stays silent.
- R10: While `run` is low nothing is sent. When `run` rises, the sequence restarts at word 0 of table entry 0, and that first slot opens with a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Slot sequencing enable; low means idle and configurable |
| cfg_we | input | 1 | Write a slot-table entry (only while idle) |
| cfg_addr | input | AW | Slot-table entry index |
| cfg_owner | input | CW | Connection owning that entry |
| cfg_len_we | input | 1 | Write the active table length (only while idle) |
| cfg_len | input | LW | Active length, 1 to SLOTS_MAX |
| in_valid | input | NCONN | Per-connection transmit word valid |
| in_ready | output | NCONN | Per-connection transmit queue has room |
| in_data | input | NCONN*DW | Transmit words, connection c at [c*DW +: DW] |
| lnk_out_valid | output | 1 | Link word valid |
| lnk_out_hdr | output | 1 | Link word is a header |
| lnk_out_data | output | DW | Link word |
| lnk_in_valid | input | 1 | Incoming link word valid |
| lnk_in_hdr | input | 1 | Incoming word is a header |
| lnk_in_data | input | DW | Incoming link word |
| rx_valid | output | NCONN | Per-connection received word valid |
| rx_ready | input | NCONN | Per-connection consumer ready |
| rx_data | output | NCONN*DW | Received words, connection c at [c*DW +: DW] |

## Verification
The assertions assume the far end honours the credits. No incoming payload word may arrive for a receive queue that is full, and returned credits never push a space counter above RMT_DEPTH. The bench ensures this by looping the link output straight back into the link input. The node then acts as its own far end, and its receive queues are at least as deep as RMT_DEPTH. All valid/ready inputs and configuration writes change just after a rising edge. Slot-table writes are made while `run` is low, except one deliberate write that checks R3.

// File: rtl/ni_pkg.sv
package ni_pkg;
  // width of the returned-credit field at the bottom of a header word
  localparam int CRED_FIELD_W = 5;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ni_fifo.sv
module ni_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW = ni_pkg::idx_w(DEPTH);
  localparam int NW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [NW-1:0] cnt_q;

  assign empty = (cnt_q == '0);
  assign full  = (int'(cnt_q) == DEPTH);
  assign dout  = mem[rd_q];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push && !full) begin
        mem[wr_q] <= din;
        wr_q      <= bump(wr_q);
      end
      if (pop && !empty) rd_q <= bump(rd_q);
      cnt_q <= cnt_q + NW'(push && !full) - NW'(pop && !empty);
    end
  end
endmodule

// File: rtl/ni_slot_table.sv
module ni_slot_table #(
  parameter int NCONN     = 2,
  parameter int SLOTS_MAX = 4,
  parameter int WPS       = 3,
  parameter int CW        = ni_pkg::idx_w(NCONN),
  parameter int AW        = ni_pkg::idx_w(SLOTS_MAX),
  parameter int LW        = $clog2(SLOTS_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [CW-1:0] cfg_owner,
  input  logic          cfg_len_we,
  input  logic [LW-1:0] cfg_len,
  output logic [CW-1:0] owner,
  output logic [CW-1:0] prev_owner,
  output logic          first
);
  localparam int WW = ni_pkg::idx_w(WPS);

  logic [CW-1:0] tbl [SLOTS_MAX];
  logic [LW-1:0] len_q;
  logic [AW-1:0] slot_q, prev_idx;
  logic [WW-1:0] word_q;
  logic          last_word, last_slot;

  assign last_word  = (int'(word_q) == WPS - 1);
  assign last_slot  = (int'(slot_q) + 1 >= int'(len_q));
  assign prev_idx   = (slot_q == '0) ? AW'(int'(len_q) - 1) : slot_q - 1'b1;
  assign owner      = tbl[slot_q];
  assign prev_owner = tbl[prev_idx];
  assign first      = (word_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS_MAX; i++) tbl[i] <= '0;
      len_q  <= LW'(1);
      slot_q <= '0;
      word_q <= '0;
    end else if (!run) begin
      slot_q <= '0;
      word_q <= '0;
      if (cfg_we && int'(cfg_addr) < SLOTS_MAX) tbl[cfg_addr] <= cfg_owner;
      if (cfg_len_we && cfg_len != '0 && int'(cfg_len) <= SLOTS_MAX) len_q <= cfg_len;
    end else if (last_word) begin
      word_q <= '0;
      slot_q <= last_slot ? '0 : slot_q + 1'b1;
    end else begin
      word_q <= word_q + 1'b1;
    end
  end

  // R3: length is frozen while slots are running
  a_r3_len_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(len_q));
  // R2: the running slot index stays inside the active part of the table
  a_r2_slot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> int'(slot_q) < int'(len_q));
endmodule

// File: rtl/ni_credit.sv
module ni_credit #(
  parameter int RMT_DEPTH = 8,
  parameter int CNT_W     = $clog2(RMT_DEPTH + 1) + 1,
  parameter int FW        = ni_pkg::CRED_FIELD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec,
  input  logic             add_en,
  input  logic [FW-1:0]    add_val,
  input  logic             pop,
  input  logic             ret,
  output logic [CNT_W-1:0] space,
  output logic             pend_nz,
  output logic [FW-1:0]    ret_amt
);
  localparam int CAP = (1 << FW) - 1;

  logic [CNT_W-1:0] space_q, pend_q;

  assign space   = space_q;
  assign pend_nz = (pend_q != '0);
  assign ret_amt = (int'(pend_q) > CAP) ? FW'(CAP) : FW'(pend_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      space_q <= CNT_W'(RMT_DEPTH);
      pend_q  <= '0;
    end else begin
      space_q <= space_q - CNT_W'(dec) + (add_en ? CNT_W'(add_val) : '0);
      pend_q  <= pend_q + CNT_W'(pop) - (ret ? CNT_W'(ret_amt) : '0);
    end
  end

  // R5: never spend a word of remote space that is not there
  a_r5_no_spend_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> space_q != '0);
  // R7: a drained word with no header going out raises the owed count by one
  a_r7_pend_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !ret) |=> pend_q == $past(pend_q) + 1'b1);
  // R8: returned credits never exceed the far queue depth
  a_r8_space_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(space_q) <= RMT_DEPTH);
endmodule

// File: rtl/tdma_ni.sv
module tdma_ni #(
  parameter int NCONN     = 2,
  parameter int DW        = 16,
  parameter int WPS       = 3,
  parameter int SLOTS_MAX = 4,
  parameter int QDEPTH    = 64,
  parameter int RMT_DEPTH = 40,
  parameter int CW        = ni_pkg::idx_w(NCONN),
  parameter int AW        = ni_pkg::idx_w(SLOTS_MAX),
  parameter int LW        = $clog2(SLOTS_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                cfg_we,
  input  logic [AW-1:0]       cfg_addr,
  input  logic [CW-1:0]       cfg_owner,
  input  logic                cfg_len_we,
  input  logic [LW-1:0]       cfg_len,
  input  logic [NCONN-1:0]    in_valid,
  output logic [NCONN-1:0]    in_ready,
  input  logic [NCONN*DW-1:0] in_data,
  output logic                lnk_out_valid,
  output logic                lnk_out_hdr,
  output logic [DW-1:0]       lnk_out_data,
  input  logic                lnk_in_valid,
  input  logic                lnk_in_hdr,
  input  logic [DW-1:0]       lnk_in_data,
  output logic [NCONN-1:0]    rx_valid,
  input  logic [NCONN-1:0]    rx_ready,
  output logic [NCONN*DW-1:0] rx_data
);
  localparam int FW    = ni_pkg::CRED_FIELD_W;
  localparam int CNT_W = $clog2(RMT_DEPTH + 1) + 1;

  logic [CW-1:0]    owner, prev_owner, rx_cur, in_id;
  logic             first;
  logic [NCONN-1:0] tx_full, tx_empty, tx_pop, rx_full, rx_empty, rx_pop, rx_push;
  logic [NCONN-1:0] cred_add, hdr_ret, pend_nz;
  logic [DW-1:0]    tx_dout [NCONN];
  logic [DW-1:0]    rx_dout [NCONN];
  logic [CNT_W-1:0] space [NCONN];
  logic [FW-1:0]    ret_amt [NCONN];

  logic             own_have, own_pend, rx_full_cur, cont, hdr_now, pay_now, pkt_q;
  logic [FW-1:0]    own_amt;
  logic [DW-1:0]    own_word, hdr_word;

  ni_slot_table #(.NCONN(NCONN), .SLOTS_MAX(SLOTS_MAX), .WPS(WPS),
                  .CW(CW), .AW(AW), .LW(LW)) i_table (
    .clk, .rst_n, .run, .cfg_we, .cfg_addr, .cfg_owner, .cfg_len_we, .cfg_len,
    .owner, .prev_owner, .first
  );

  assign in_id = lnk_in_data[FW +: CW];

  for (genvar c = 0; c < NCONN; c++) begin : g_conn
    assign in_ready[c] = !tx_full[c];
    assign tx_pop[c]   = pay_now && (owner == CW'(c));
    assign hdr_ret[c]  = hdr_now && (owner == CW'(c));
    assign rx_push[c]  = lnk_in_valid && !lnk_in_hdr && (rx_cur == CW'(c));
    assign cred_add[c] = lnk_in_valid && lnk_in_hdr && (in_id == CW'(c));
    assign rx_valid[c] = !rx_empty[c];
    assign rx_pop[c]   = rx_valid[c] && rx_ready[c];
    assign rx_data[c*DW +: DW] = rx_dout[c];

    ni_fifo #(.W(DW), .DEPTH(QDEPTH)) i_txq (
      .clk, .rst_n, .push(in_valid[c] && in_ready[c]), .din(in_data[c*DW +: DW]),
      .pop(tx_pop[c]), .dout(tx_dout[c]), .full(tx_full[c]), .empty(tx_empty[c])
    );
    ni_fifo #(.W(DW), .DEPTH(QDEPTH)) i_rxq (
      .clk, .rst_n, .push(rx_push[c]), .din(lnk_in_data),
      .pop(rx_pop[c]), .dout(rx_dout[c]), .full(rx_full[c]), .empty(rx_empty[c])
    );
    ni_credit #(.RMT_DEPTH(RMT_DEPTH), .CNT_W(CNT_W), .FW(FW)) i_cred (
      .clk, .rst_n, .dec(tx_pop[c]), .add_en(cred_add[c]),
      .add_val(lnk_in_data[FW-1:0]), .pop(rx_pop[c]), .ret(hdr_ret[c]),
      .space(space[c]), .pend_nz(pend_nz[c]), .ret_amt(ret_amt[c])
    );
  end

  // state of the slot owner and of the connection currently receiving
  always_comb begin
    own_have    = 1'b0;
    own_pend    = 1'b0;
    own_amt     = '0;
    own_word    = '0;
    rx_full_cur = 1'b0;
    for (int c = 0; c < NCONN; c++) begin
      if (owner == CW'(c)) begin
        own_have = !tx_empty[c] && (space[c] != '0);
        own_pend = pend_nz[c];
        own_amt  = ret_amt[c];
        own_word = tx_dout[c];
      end
      if (rx_cur == CW'(c)) rx_full_cur = rx_full[c];
    end
  end

  always_comb begin
    hdr_word            = '0;
    hdr_word[FW-1:0]    = own_amt;
    hdr_word[FW +: CW]  = owner;
  end

  // continuation: same owner as the previous slot, a packet was open there, nothing owed
  assign cont    = pkt_q && (prev_owner == owner) && !own_pend;
  assign hdr_now = run && first && !cont && (own_have || own_pend);
  assign pay_now = run && own_have && (first ? cont : pkt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_q         <= 1'b0;
      rx_cur        <= '0;
      lnk_out_valid <= 1'b0;
      lnk_out_hdr   <= 1'b0;
      lnk_out_data  <= '0;
    end else begin
      if (!run)       pkt_q <= 1'b0;
      else if (first) pkt_q <= cont || hdr_now;
      if (lnk_in_valid && lnk_in_hdr) rx_cur <= in_id;
      lnk_out_valid <= hdr_now || pay_now;
      lnk_out_hdr   <= hdr_now;
      lnk_out_data  <= hdr_now ? hdr_word : own_word;
    end
  end

  // R4: a header only ever leaves as the first word of a slot
  a_r4_hdr_at_slot_start: assert property (@(posedge clk) disable iff (!rst_n)
    (lnk_out_valid && lnk_out_hdr) |-> $past(first));
  // R10: nothing on the link after a cycle with run low
  a_r10_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> !lnk_out_valid);
  // R8: the far end never sends payload into a full receive queue
  a_r8_rx_room: assert property (@(posedge clk) disable iff (!rst_n)
    (lnk_in_valid && !lnk_in_hdr) |-> !rx_full_cur);
endmodule

// File: tb/test_tdma_ni.sv
module test_tdma_ni;
  localparam int CLK_P = 10;
  localparam int WPS   = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        cfg_we = 1'b0, cfg_len_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [0:0]  cfg_owner = '0;
  logic [2:0]  cfg_len = '0;
  logic [1:0]  in_valid = '0, in_ready, rx_valid, rx_ready = '0;
  logic [31:0] in_data = '0, rx_data;
  logic        lnk_valid, lnk_hdr;
  logic [15:0] lnk_data;

  always #(CLK_P/2) clk = ~clk;

  tdma_ni i_tdma_ni (
    .clk, .rst_n, .run, .cfg_we, .cfg_addr, .cfg_owner, .cfg_len_we, .cfg_len,
    .in_valid, .in_ready, .in_data,
    .lnk_out_valid(lnk_valid), .lnk_out_hdr(lnk_hdr), .lnk_out_data(lnk_data),
    .lnk_in_valid(lnk_valid), .lnk_in_hdr(lnk_hdr), .lnk_in_data(lnk_data),
    .rx_valid, .rx_ready, .rx_data
  );

  int checks = 0, fails = 0;
  bit done = 0;
  int seq_in [2];
  int rx_seen [2];
  int pay [2];
  int cred_sum [2];
  int cr0_v [2];
  int hdr_cnt, pay_off0, off_bad, slot2_cnt, idle_viol, cr0_n, cur, tlen = 3;
  int cnt = 0, out_idx = 0;
  bit out_live = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_mon();
    hdr_cnt = 0; pay_off0 = 0; off_bad = 0; slot2_cnt = 0; cr0_n = 0;
    for (int c = 0; c < 2; c++) begin pay[c] = 0; cred_sum[c] = 0; cr0_v[c] = 0; end
  endtask

  task automatic push(input int c, input int n);
    for (int i = 0; i < n; i++) begin
      in_valid[c] = 1'b1;
      in_data[c*16 +: 16] = 16'((c << 8) | seq_in[c]);
      tick(1);
      seq_in[c]++;
    end
    in_valid[c] = 1'b0;
  endtask

  task automatic set_slot(input int a, input int o);
    cfg_we = 1'b1; cfg_addr = 2'(a); cfg_owner = 1'(o);
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic set_len(input int l);
    cfg_len_we = 1'b1; cfg_len = 3'(l);
    tick(1);
    cfg_len_we = 1'b0;
  endtask

  // decision index of the word now on the link
  always @(posedge clk) begin
    if (run) begin out_idx <= cnt; out_live <= 1'b1; cnt <= cnt + 1; end
    else begin out_live <= 1'b0; cnt <= 0; end
  end

  // link monitor and receive scoreboard
  always @(negedge clk) begin
    if (rst_n && lnk_valid) begin
      if (!out_live) idle_viol++;
      else begin
        if (((out_idx / WPS) % tlen) == 2) slot2_cnt++;
        if (lnk_hdr) begin
          cur = int'(lnk_data[5]);
          hdr_cnt++;
          if (out_idx % WPS != 0) off_bad++;
          cred_sum[cur] += int'(lnk_data[4:0]);
          if (cur == 0 && lnk_data[4:0] != 0 && cr0_n < 2) begin
            cr0_v[cr0_n] = int'(lnk_data[4:0]);
            cr0_n++;
          end
        end else begin
          pay[cur]++;
          if (out_idx % WPS == 0) pay_off0++;
        end
      end
    end
    for (int c = 0; c < 2; c++) begin
      if (rst_n && rx_valid[c] && rx_ready[c]) begin
        chk(rx_data[c*16 +: 16] == 16'((c << 8) | rx_seen[c]), "R8 in-order delivery",
            int'(rx_data[c*16 +: 16]), (c << 8) | rx_seen[c]);
        rx_seen[c]++;
      end
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 2; c++) begin seq_in[c] = 0; rx_seen[c] = 0; end
    clear_mon();
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1: reset state at the ports
    chk(!lnk_valid, "R1 link idle", int'(lnk_valid), 0);
    chk(in_ready == 2'b11, "R1 tx ready", int'(in_ready), 3);
    chk(rx_valid == 2'b00, "R1 rx empty", int'(rx_valid), 0);

    // Phase B: table 0,0,1; plenty of data; consumers stalled
    set_slot(0, 0); set_slot(1, 0); set_slot(2, 1); set_len(3);
    push(0, 30); push(1, 30);
    tick(5);
    chk(idle_viol == 0, "R10 silent while idle", idle_viol, 0);
    clear_mon();
    run = 1'b1; tick(36); run = 1'b0; tick(4);
    chk(hdr_cnt == 8, "R4 header count", hdr_cnt, 8);
    chk(pay[0] == 20, "R2 conn0 words per 4 revolutions", pay[0], 20);
    chk(pay[1] == 8, "R2 conn1 words per 4 revolutions", pay[1], 8);
    chk(pay_off0 == 4, "R4 continuation slot starts with payload", pay_off0, 4);
    chk(off_bad == 0, "R4 header only at word 0", off_bad, 0);

    // Phase C: conn0 runs out of remote space, conn1 keeps going
    push(0, 30);
    clear_mon();
    run = 1'b1; tick(180); run = 1'b0; tick(4);
    chk(pay[0] == 20, "R5 conn0 stops at RMT_DEPTH total", pay[0], 20);
    chk(pay[1] == 22, "R6 conn1 unaffected by stalled conn0", pay[1], 22);
    chk(rx_valid == 2'b11, "R6 both receive queues hold data", int'(rx_valid), 3);

    // Phase D: drain everything, then credits flow back
    rx_ready = 2'b11; tick(50); rx_ready = 2'b00; tick(2);
    chk(rx_seen[0] == 40, "R1 conn0 delivered RMT_DEPTH words", rx_seen[0], 40);
    chk(rx_seen[1] == 30, "R8 conn1 delivered all words", rx_seen[1], 30);
    clear_mon();
    run = 1'b1; tick(90); run = 1'b0; tick(4);
    chk(cr0_n == 2 && cr0_v[0] == 31, "R7 first return capped at 31", cr0_v[0], 31);
    chk(cr0_v[1] == 9, "R7 remainder in next own header", cr0_v[1], 9);
    chk(cred_sum[0] == 40, "R8 conn0 credits returned", cred_sum[0], 40);
    chk(cred_sum[1] == 30, "R9 header-only carries conn1 credits", cred_sum[1], 30);
    chk(pay[1] == 0, "R9 header-only has no payload", pay[1], 0);
    chk(slot2_cnt == 1, "R9 later empty slots silent", slot2_cnt, 1);
    chk(pay[0] == 20, "R5 conn0 resumes after credits", pay[0], 20);

    // Phase E: config write during run is ignored
    push(1, 3);
    clear_mon();
    run = 1'b1; cfg_we = 1'b1; cfg_addr = 2'd2; cfg_owner = 1'b0;
    cfg_len_we = 1'b1; cfg_len = 3'd1;
    tick(1);
    cfg_we = 1'b0; cfg_len_we = 1'b0;
    tick(8); run = 1'b0; tick(4);
    chk(pay[1] == 2, "R3 table unchanged by write while running", pay[1], 2);

    // Phase F: single-entry table, continuation across revolutions
    set_len(1); tlen = 1;
    push(0, 9);
    clear_mon();
    run = 1'b1; tick(9); run = 1'b0; tick(4);
    chk(hdr_cnt == 1, "R10 only the first slot has a header", hdr_cnt, 1);
    chk(pay[0] == 8, "R4 conn0 payload over 3 slots", pay[0], 8);
    chk(pay_off0 == 2, "R4 continuation slots all payload", pay_off0, 2);

    // final drain
    rx_ready = 2'b11; tick(100); rx_ready = 2'b00; tick(2);
    chk(rx_seen[0] == 68, "R8 conn0 total delivered", rx_seen[0], 68);
    chk(rx_seen[1] == 32, "R8 conn1 total delivered", rx_seen[1], 32);
    chk(idle_viol == 0, "R10 no words outside run", idle_viol, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule